// File: doc/BRIEF.md
# Three-Wire Addressless Serial Master

This block is a hardware master for a three-wire serial link to a clock chip that has no internal register addressing: every access moves one whole frame. It drives a chip-enable line, a direction line (high to write, low to read) and a serial clock. It controls one bidirectional data pin through a separate output-enable and a data-in return. A host hands over a request with a direction, a bit count from 0 to `MAX_BITS`, and a packed frame. On a read, the block returns the packed received frame.

The request side is a valid/ready port. `start_ready` is high only while the block is idle, and a request is taken on the clock edge where `start_valid` and `start_ready` are both high. A host that raises `start_valid` while the block is busy is simply not accepted, which is how back-pressure works. The result side has no back-pressure. `done` pulses for one cycle, and `rd_frame` keeps its value until the next read is accepted, so the host may collect it at any time.

Frame bit i is the i-th bit on the wire. Frame byte 0 goes first, and each byte goes least-significant bit first. All delays are whole numbers of system cycles: `SETUP_US*CYC_PER_US` cycles (S) for each setup delay and `HALF_US*CYC_PER_US` cycles (H) for each clock phase.

Top module: `twire_master`

## Requirements
- R1: A request is accepted only while `start_ready` is high, which is exactly while `busy` is low. A request presented while busy starts nothing and does not change the transfer in flight.
- R2: On the accept edge, `bus_wr` takes the direction (1 = write, 0 = read). It holds that value until chip enable falls, and then returns to 0.
- R3: `bus_ce` rises S cycles after the accept edge. The first rising edge of `bus_sclk` follows S+1 cycles after that.
- R4: Each bit has `bus_sclk` high for exactly H cycles. The clock is low for H+1 cycles between consecutive bits, made of one data-lead cycle plus H. `bus_sclk` is high only while `bus_ce` is high.
- R5: On a write, frame bit i is on `bus_dout` before the i-th rising clock edge. It stays unchanged from that edge until the clock-low phase after it ends.
- R6: `bus_doe` is high only during write transfers, from the accept edge until chip enable falls. It is never high during a read.
- R7: On a read, `bus_din` is sampled in the last system cycle of each clock-high phase. The value from the i-th clock pulse lands in `rd_frame` bit i.
- R8: Accepting a read clears `rd_frame`, so bits at positions at or above the bit count read as 0. A write leaves `rd_frame` unchanged.
- R9: Exactly as many clock pulses are issued as the bit count. Chip enable falls H cycles after the last clock falls. A count of 0 gives no pulse, and chip enable then stays high for S cycles.
- R10: `busy` is high from the accept edge until chip enable falls. `done` is a one-cycle pulse on the same edge where chip enable falls.
- R11: After reset, `bus_ce`, `bus_wr`, `bus_sclk`, `bus_dout`, `bus_doe`, `busy`, `done` and `rd_frame` are all 0, and `start_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Request valid |
| start_ready | output | 1 | Request accepted when high together with valid (idle) |
| start_write | input | 1 | Request direction, 1 = write |
| start_nbits | input | $clog2(MAX_BITS+1) | Number of bits to transfer |
| start_frame | input | MAX_BITS | Packed write frame, bit 0 first |
| rd_frame | output | MAX_BITS | Packed received frame |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| bus_ce | output | 1 | Chip enable to the device |
| bus_wr | output | 1 | Direction line to the device |
| bus_sclk | output | 1 | Serial clock to the device |
| bus_dout | output | 1 | Data driven onto the pin |
| bus_doe | output | 1 | Output enable of the data pin |
| bus_din | input | 1 | Data read from the pin |

## Verification
The properties assume a correct request: `start_nbits` is never above `MAX_BITS`, and both S and H are at least 1. They also assume `bus_din` is only meaningful while the clock is high. The stimulus uses counts between 0 and 64 with S=2 and H=4. It drives requests one cycle after a rising edge, and its device model changes `bus_din` only while the clock is low. A request that overlaps a running transfer is made deliberately, to check that it is refused.

// File: rtl/twire_pkg.sv
package twire_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_CES,
    ST_LEAD,
    ST_HIGH,
    ST_LOW
  } twire_state_e;
endpackage

// File: rtl/twire_timer.sv
module twire_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/twire_shifter.sv
module twire_shifter #(
  parameter int MAX_BITS = 64,
  parameter int IW       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                load_read,
  input  logic [IW-1:0]       load_nbits,
  input  logic [MAX_BITS-1:0] load_frame,
  input  logic                capture,
  input  logic                advance,
  input  logic                din,
  output logic                cur_bit,
  output logic                nxt_bit,
  output logic                last,
  output logic                empty,
  output logic [MAX_BITS-1:0] rx_frame
);
  logic [MAX_BITS-1:0] tx;
  logic [IW-1:0]       idx;
  logic [IW-1:0]       nbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx    <= '0;
      idx   <= '0;
      nbits <= '0;
    end else if (load) begin
      tx    <= load_frame;
      idx   <= '0;
      nbits <= load_nbits;
    end else if (advance) begin
      tx    <= tx >> 1;
      idx   <= idx + 1'b1;
    end
  end

  for (genvar i = 0; i < MAX_BITS; i++) begin : g_rx
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         rx_frame[i] <= 1'b0;
      else if (load && load_read)         rx_frame[i] <= 1'b0;
      else if (capture && idx == IW'(i))  rx_frame[i] <= din;
    end
  end

  assign cur_bit = tx[0];
  assign nxt_bit = tx[1];
  assign last    = ((idx + 1'b1) == nbits);
  assign empty   = (nbits == '0);
endmodule

// File: rtl/twire_master.sv
module twire_master #(
  parameter int MAX_BITS   = 64,
  parameter int CYC_PER_US = 50,
  parameter int SETUP_US   = 1,
  parameter int HALF_US    = 10,
  parameter int NBW        = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_valid,
  output logic                start_ready,
  input  logic                start_write,
  input  logic [NBW-1:0]      start_nbits,
  input  logic [MAX_BITS-1:0] start_frame,
  output logic [MAX_BITS-1:0] rd_frame,
  output logic                busy,
  output logic                done,
  output logic                bus_ce,
  output logic                bus_wr,
  output logic                bus_sclk,
  output logic                bus_dout,
  output logic                bus_doe,
  input  logic                bus_din
);
  import twire_pkg::*;

  localparam int SETUP_CYC = SETUP_US * CYC_PER_US;
  localparam int HALF_CYC  = HALF_US * CYC_PER_US;
  localparam int MAX_CYC   = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);

  twire_state_e st, nxt;
  logic          t_load, t_exp;
  logic [TW-1:0] t_val;
  logic          sh_load, cap, adv, fin;
  logic          rd_mode;
  logic          cur_bit, nxt_bit, last, empty;

  twire_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .expired(t_exp)
  );

  twire_shifter #(.MAX_BITS(MAX_BITS), .IW(NBW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_read(!start_write),
    .load_nbits(start_nbits), .load_frame(start_frame), .capture(cap),
    .advance(adv), .din(bus_din), .cur_bit(cur_bit), .nxt_bit(nxt_bit),
    .last(last), .empty(empty), .rx_frame(rd_frame)
  );

  always_comb begin
    nxt     = st;
    t_load  = 1'b0;
    t_val   = '0;
    sh_load = 1'b0;
    cap     = 1'b0;
    adv     = 1'b0;
    fin     = 1'b0;
    case (st)
      ST_IDLE: if (start_valid) begin
        nxt = ST_DIR; t_load = 1'b1; t_val = TW'(SETUP_CYC - 1); sh_load = 1'b1;
      end
      ST_DIR: if (t_exp) begin
        nxt = ST_CES; t_load = 1'b1; t_val = TW'(SETUP_CYC - 1);
      end
      ST_CES: if (t_exp) begin
        if (empty) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else begin
          nxt = ST_LEAD; t_load = 1'b1;
        end
      end
      ST_LEAD: if (t_exp) begin
        nxt = ST_HIGH; t_load = 1'b1; t_val = TW'(HALF_CYC - 1);
      end
      ST_HIGH: if (t_exp) begin
        nxt = ST_LOW; t_load = 1'b1; t_val = TW'(HALF_CYC - 1); cap = rd_mode;
      end
      ST_LOW: if (t_exp) begin
        if (last) begin
          nxt = ST_IDLE; fin = 1'b1;
        end else begin
          nxt = ST_LEAD; t_load = 1'b1; adv = 1'b1;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      done     <= 1'b0;
      rd_mode  <= 1'b0;
      bus_ce   <= 1'b0;
      bus_wr   <= 1'b0;
      bus_sclk <= 1'b0;
      bus_dout <= 1'b0;
      bus_doe  <= 1'b0;
    end else begin
      st   <= nxt;
      done <= fin;
      if (st == ST_IDLE && start_valid) begin
        bus_wr  <= start_write;
        bus_doe <= start_write;
        rd_mode <= !start_write;
      end
      if (st == ST_DIR && t_exp) bus_ce <= 1'b1;
      if (st == ST_CES && t_exp && !empty) bus_dout <= !rd_mode && cur_bit;
      if (st == ST_LEAD && t_exp) bus_sclk <= 1'b1;
      if (st == ST_HIGH && t_exp) bus_sclk <= 1'b0;
      if (st == ST_LOW && t_exp && !last) bus_dout <= !rd_mode && nxt_bit;
      if (fin) begin
        bus_ce   <= 1'b0;
        bus_wr   <= 1'b0;
        bus_doe  <= 1'b0;
        bus_dout <= 1'b0;
      end
    end
  end

  assign busy        = (st != ST_IDLE);
  assign start_ready = (st == ST_IDLE);
endmodule

// File: rtl/twire_master_chk.sv
module twire_master_chk #(
  parameter int MAX_BITS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_valid,
  input logic                busy,
  input logic                done,
  input logic [MAX_BITS-1:0] rd_frame,
  input logic                bus_ce,
  input logic                bus_wr,
  input logic                bus_sclk,
  input logic                bus_dout,
  input logic                bus_doe
);
  // R1
  accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_valid));

  // R2
  wr_before_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ce) |-> $stable(bus_wr));

  // R4
  sclk_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sclk |-> bus_ce);

  // R5
  dout_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_sclk) |-> $stable(bus_dout));

  // R5
  dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_sclk) |-> $stable(bus_dout));

  // R6
  doe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_doe |-> bus_wr);

  // R8
  rdframe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> $stable(rd_frame));

  // R9
  ce_fall_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ce) |-> (!bus_sclk && $past(!bus_sclk)));

  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !bus_ce && $past(bus_ce)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind twire_master twire_master_chk #(.MAX_BITS(MAX_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .busy(busy),
  .done(done), .rd_frame(rd_frame), .bus_ce(bus_ce), .bus_wr(bus_wr),
  .bus_sclk(bus_sclk), .bus_dout(bus_dout), .bus_doe(bus_doe)
);

// File: tb/twire_master_test.sv
module twire_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 2;
  localparam int SU  = 1;
  localparam int HU  = 2;
  localparam int S   = SU * CPU;
  localparam int H   = HU * CPU;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_write = 1'b0;
  logic [6:0]  start_nbits = '0;
  logic [63:0] start_frame = '0;
  logic        start_ready, busy, done;
  logic [63:0] rd_frame;
  logic        bus_ce, bus_wr, bus_sclk, bus_dout, bus_doe, bus_din;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twire_master #(.MAX_BITS(64), .CYC_PER_US(CPU), .SETUP_US(SU), .HALF_US(HU)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_write(start_write), .start_nbits(start_nbits), .start_frame(start_frame),
    .rd_frame(rd_frame), .busy(busy), .done(done), .bus_ce(bus_ce), .bus_wr(bus_wr),
    .bus_sclk(bus_sclk), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
  );

  // device model and bus monitor, sampled on the falling clock edge
  int cyc = 0, t_acc = 0, t_wr_r = 0, t_ce_r = 0, t_ce_f = 0, t_first = 0;
  int t_rise = 0, t_fall = 0, t_done = 0, pulses = 0, dones = 0;
  int hi_err = 0, gap_err = 0, su_err = 0, hd_err = 0;
  logic doe_seen = 1'b0, wr_seen = 1'b0;
  logic p_ce = 1'b0, p_wr = 1'b0, p_sclk = 1'b0, p_dout = 1'b0;
  logic [63:0] wcap = '0, dev_pat = '0;

  assign bus_din = (pulses < 64) ? dev_pat[pulses[5:0]] : 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (start_valid && start_ready) t_acc = cyc;
    if (bus_wr && !p_wr) t_wr_r = cyc;
    if (bus_wr) wr_seen = 1'b1;
    if (bus_doe) doe_seen = 1'b1;
    if (bus_ce && !p_ce) begin t_ce_r = cyc; pulses = 0; end
    if (bus_sclk && !p_sclk) begin
      if (pulses == 0) t_first = cyc;
      else if (cyc - t_fall != H + 1) gap_err++;
      if (bus_dout != p_dout) su_err++;
      if (pulses < 64) wcap[pulses[5:0]] = bus_dout;
      t_rise = cyc;
    end
    if (p_sclk && bus_dout != p_dout) hd_err++;
    if (!bus_sclk && p_sclk) begin
      if (cyc - t_rise != H) hi_err++;
      t_fall = cyc;
      pulses = pulses + 1;
    end
    if (!bus_ce && p_ce) t_ce_f = cyc;
    if (done) begin t_done = cyc; dones++; end
    p_ce = bus_ce; p_wr = bus_wr; p_sclk = bus_sclk; p_dout = bus_dout;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mask_of(input int nb);
    logic [63:0] m = '0;
    for (int i = 0; i < nb; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic clear_mon();
    hi_err = 0; gap_err = 0; su_err = 0; hd_err = 0;
    doe_seen = 1'b0; wr_seen = 1'b0; wcap = '0;
  endtask

  task automatic launch(input logic wr, input int nb, input logic [63:0] fr);
    @(posedge clk); #1;
    clear_mon();
    start_valid = 1'b1; start_write = wr; start_nbits = 7'(nb); start_frame = fr;
    @(posedge clk); #1;
    start_valid = 1'b0;
  endtask

  task automatic wait_done();
    int n = dones;
    int k = 0;
    while (dones == n && k < 5000) begin
      @(negedge clk); #1;
      k++;
    end
    chk(dones != n, "R10 watchdog: done never seen", 64'(k), 64'd0);
  endtask

  task automatic t_reset();
    chk(!bus_ce && !bus_wr && !bus_sclk && !bus_dout && !bus_doe, "R11 bus lines idle",
        {59'd0, bus_ce, bus_wr, bus_sclk, bus_dout, bus_doe}, 64'd0);
    chk(start_ready && !busy && !done, "R11 handshake idle",
        {61'd0, start_ready, busy, done}, 64'h4);
    chk(rd_frame == '0, "R11 rd_frame cleared", rd_frame, 64'd0);
  endtask

  task automatic t_write(input int nb, input logic [63:0] fr);
    logic [63:0] m = mask_of(nb);
    logic [63:0] keep = rd_frame;
    launch(1'b1, nb, fr);
    wait_done();
    chk(pulses == nb, "R9 write pulse count", 64'(pulses), 64'(nb));
    chk((wcap & m) == (fr & m), "R5 write bit order", wcap & m, fr & m);
    chk(t_wr_r == t_acc + 1, "R2 wr set at accept", 64'(t_wr_r), 64'(t_acc + 1));
    chk(t_ce_r - t_wr_r == S, "R3 ce after wr", 64'(t_ce_r - t_wr_r), 64'(S));
    chk(t_first - t_ce_r == S + 1, "R3 first clock after ce", 64'(t_first - t_ce_r), 64'(S + 1));
    chk(hi_err == 0 && gap_err == 0, "R4 clock phases", 64'(hi_err + gap_err), 64'd0);
    chk(su_err == 0 && hd_err == 0, "R5 data setup/hold", 64'(su_err + hd_err), 64'd0);
    chk(t_ce_f - t_fall == H, "R9 ce falls after last low", 64'(t_ce_f - t_fall), 64'(H));
    chk(t_done == t_ce_f, "R10 done with ce fall", 64'(t_done), 64'(t_ce_f));
    chk(doe_seen, "R6 doe during write", 64'(doe_seen), 64'd1);
    chk(!bus_wr && !bus_doe && !busy, "R2 lines released", {61'd0, bus_wr, bus_doe, busy}, 64'd0);
    chk(rd_frame == keep, "R8 write keeps rd_frame", rd_frame, keep);
  endtask

  task automatic t_read(input int nb, input logic [63:0] pat);
    logic [63:0] m = mask_of(nb);
    dev_pat = pat;
    launch(1'b0, nb, ~pat);
    wait_done();
    chk(pulses == nb, "R9 read pulse count", 64'(pulses), 64'(nb));
    chk(rd_frame == (pat & m), "R7 R8 read frame", rd_frame, pat & m);
    chk(!wr_seen && !doe_seen, "R2 R6 read keeps wr and doe low", {62'd0, wr_seen, doe_seen}, 64'd0);
    chk(t_ce_r == t_acc + 1 + S, "R3 ce after accept", 64'(t_ce_r), 64'(t_acc + 1 + S));
    chk(hi_err == 0 && gap_err == 0, "R4 read clock phases", 64'(hi_err + gap_err), 64'd0);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] keep = rd_frame;
    launch(1'b1, 8, 64'hA5);
    repeat (10) @(posedge clk);
    #1;
    chk(!start_ready && busy, "R1 R10 ready low while busy", {62'd0, start_ready, busy}, 64'd1);
    start_valid = 1'b1; start_write = 1'b0; start_nbits = 7'd16;
    @(posedge clk); #1;
    start_valid = 1'b0;
    wait_done();
    chk(pulses == 8, "R1 late request ignored", 64'(pulses), 64'd8);
    chk(rd_frame == keep, "R1 rd_frame untouched", rd_frame, keep);
    repeat (20) @(posedge clk);
    #1;
    chk(!bus_ce && !busy, "R1 no second transfer", {62'd0, bus_ce, busy}, 64'd0);
  endtask

  task automatic t_zero();
    launch(1'b0, 0, 64'd0);
    wait_done();
    chk(pulses == 0, "R9 zero count no pulse", 64'(pulses), 64'd0);
    chk(t_ce_f - t_ce_r == S, "R9 zero count ce width", 64'(t_ce_f - t_ce_r), 64'(S));
    chk(rd_frame == '0, "R8 zero-length read clears", rd_frame, 64'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    t_write(64, 64'h0123_4567_89AB_CDEF);
    t_write(52, 64'hFFF5_A3C1_9E07_7B2D);
    t_read(64, 64'hFFFF_FFFF_FFFF_FFFF);
    t_read(13, 64'hDEAD_BEEF_CAFE_F00D);
    t_read(52, 64'h8F3C_96E1_5A0F_C3B7);
    t_busy_ignore();
    t_zero();
    t_write(1, 64'h1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule